// File: doc/BRIEF.md
# Pilot Identification Search Sequencer

This block is the digital timing and decision controller of a TV stereo/dual identification decoder. It drives a filter-select output that switches the external narrow band-pass filter between a dual-sound search window and a stereo search window. The two windows share a full search period equally. The raw "sideband present" bit from the rectifier is sampled on a derived timebase. An up/down integrator accumulates these samples, and a comparator turns the total into a decision. Once a mode is confirmed, the alternation freezes on that mode and the status output reports it. If the sideband then goes away, searching starts again from the dual window.

The timebase comes from a line-rate reference tick. The tick runs either at line rate or at four times line rate, and the block divides it so that the sample rate is the same in both cases. A period-select input scales the search period, the lock threshold and the release threshold together. A search-enable input is low after power-on. While it is low, the block is held in mono.

Top module: `pilot_id_seq`

## Requirements
- R1: While search_en is 0, id_status reads mono (2'b00), filt_stereo stays 0 and locked stays 0, whatever det_raw does.
- R2: One sample is taken every LINES_PER_SAMPLE reference ticks when ref_x4 is 0, and every 4*LINES_PER_SAMPLE ticks when ref_x4 is 1. With the reference running four times faster in the second case, the sample timing is therefore identical.
- R3: A half window lasts H = HALF_BASE<<per_sel samples for per_sel 0, 1 and 2. These are the 2x, 4x and 8x periods. Searching starts in the dual half (filt_stereo=0), and filt_stereo toggles at the end of every half.
- R4: The integrator adds one on each sample where det_raw is 1 and subtracts one otherwise. It saturates at 0 and at H, and it is cleared at every change of half.
- R5: A lock is declared when the integrator reaches H/2. With det_raw held high from the start of a half, lock comes H/2 samples in, which is one quarter of the full period.
- R6: Isolated detect hits (one sample high in four) never produce a lock.
- R7: Once locked, filt_stereo no longer toggles. id_status reports stereo (2'b01) when locked in the stereo half and dual (2'b10) when locked in the dual half.
- R8: While locked, if the integrator drops below H/4, the lock is released. id_status returns to mono, and searching resumes in the dual half for a full H samples.
- R9: per_sel = 2'b11 is reserved. With search_en at 1, it stops the search and id_status reads inhibited (2'b11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference period (line rate or four times line rate) |
| ref_x4 | input | 1 | 0: reference tick at line rate, 1: at four times line rate |
| per_sel | input | 2 | Search period select: 0, 1, 2 double the period each step; 3 reserved |
| search_en | input | 1 | 0 holds the decoder in mono; 1 allows searching |
| det_raw | input | 1 | Raw sideband-present bit from the rectifier |
| filt_stereo | output | 1 | Filter select: 0 dual window, 1 stereo window |
| id_status | output | 2 | Decision: 00 mono, 01 stereo, 10 dual, 11 inhibited |
| locked | output | 1 | High while a mode is confirmed |

## Verification
Several properties are checked on every cycle. The window select must stay frozen while held, and it must flip on every half change. The integrator must hold still between samples and clear when told to. The select must agree with the locked mode, and disabled search must give mono. Other behaviour can only be shown by the bench's timed scenarios. These cover the half length for each period code and reference rate, lock and release latency measured in samples, saturation as seen through the release delay, and the clearing of the integrator at a half boundary. The noise rejection of sparse detect hits also needs the bench.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [1:0] {
    ST_MONO   = 2'b00,
    ST_STEREO = 2'b01,
    ST_DUAL   = 2'b10,
    ST_INHIB  = 2'b11
  } id_status_e;

  // Samples in one half window for a period code (0..2).
  function automatic int unsigned half_samples(int unsigned base, logic [1:0] per);
    return base << per;
  endfunction

  // Integrator level at which a mode is confirmed.
  function automatic int unsigned lock_level(int unsigned half);
    return half >> 1;
  endfunction

  // Integrator level below which a lock is dropped.
  function automatic int unsigned release_level(int unsigned half);
    return half >> 2;
  endfunction

endpackage

// File: rtl/pid_timebase.sv
module pid_timebase #(
  parameter int unsigned LINES_PER_SAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_tick,
  input  logic ref_x4,
  output logic samp_tick
);
  localparam int unsigned MAXDIV = 4 * LINES_PER_SAMPLE;
  localparam int unsigned CW = $clog2(MAXDIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  assign last_w = ref_x4 ? CW'(MAXDIV - 1) : CW'(LINES_PER_SAMPLE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      samp_tick <= 1'b0;
    end else if (clr) begin
      cnt_q     <= '0;
      samp_tick <= 1'b0;
    end else if (ref_tick) begin
      if (cnt_q >= last_w) begin
        cnt_q     <= '0;
        samp_tick <= 1'b1;
      end else begin
        cnt_q     <= cnt_q + 1'b1;
        samp_tick <= 1'b0;
      end
    end else begin
      samp_tick <= 1'b0;
    end
  end

  // R2: a sample pulse needs a reference tick in the cycle before it
  p_samp_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |-> $past(ref_tick));

endmodule

// File: rtl/pid_window.sv
module pid_window #(
  parameter int unsigned HALF_BASE = 977
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       restart,
  input  logic       hold,
  input  logic       samp_tick,
  input  logic [1:0] per_sel,
  output logic       sel_stereo,
  output logic       half_chg
);
  import pid_pkg::*;

  localparam int unsigned MAXH = HALF_BASE * 4;
  localparam int unsigned HW = $clog2(MAXH + 1);

  logic [HW-1:0] hcnt_q;
  logic [HW-1:0] last_w;

  assign last_w   = HW'(half_samples(HALF_BASE, per_sel) - 1);
  assign half_chg = samp_tick && !hold && !clr && !restart && (hcnt_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q     <= '0;
      sel_stereo <= 1'b0;
    end else if (clr || restart) begin
      hcnt_q     <= '0;
      sel_stereo <= 1'b0;
    end else if (half_chg) begin
      hcnt_q     <= '0;
      sel_stereo <= ~sel_stereo;
    end else if (samp_tick && !hold) begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  // R7: a held window never changes its select
  p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr && !restart) |=> $stable(sel_stereo));

  // R3: every half change flips the select
  p_half_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_chg |=> (sel_stereo != $past(sel_stereo)));

  // R8: a restart always returns to the dual half
  p_restart_dual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sel_stereo);

endmodule

// File: rtl/pid_integrator.sv
module pid_integrator #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          samp_tick,
  input  logic          det,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (samp_tick) begin
      if (det) begin
        if (acc < limit) acc <= acc + 1'b1;
        else             acc <= limit;
      end else if (acc != '0) begin
        acc <= acc - 1'b1;
      end
    end
  end

  // R4: level only moves on a sample
  p_still_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !samp_tick) |=> $stable(acc));

  // R4: a clear empties the integrator
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

endmodule

// File: rtl/pilot_id_seq.sv
module pilot_id_seq #(
  parameter int unsigned LINES_PER_SAMPLE = 16,
  parameter int unsigned HALF_BASE        = 977
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       ref_x4,
  input  logic [1:0] per_sel,
  input  logic       search_en,
  input  logic       det_raw,
  output logic       filt_stereo,
  output logic [1:0] id_status,
  output logic       locked
);
  import pid_pkg::*;

  localparam int unsigned MAXH = HALF_BASE * 4;
  localparam int unsigned AW = $clog2(MAXH + 1);

  logic          run_w;
  logic          samp_w;
  logic          half_chg_w;
  logic          sel_w;
  logic          lock_go_w;
  logic          restart_w;
  logic          hold_w;
  logic          int_clr_w;
  logic [AW-1:0] half_w;
  logic [AW-1:0] lock_lv_w;
  logic [AW-1:0] rel_lv_w;
  logic [AW-1:0] acc_w;
  logic          lock_q;
  logic          mode_q;
  id_status_e    status_w;

  assign run_w     = search_en && (per_sel != 2'b11);
  assign half_w    = AW'(half_samples(HALF_BASE, per_sel));
  assign lock_lv_w = AW'(lock_level(half_samples(HALF_BASE, per_sel)));
  assign rel_lv_w  = AW'(release_level(half_samples(HALF_BASE, per_sel)));

  assign lock_go_w = run_w && !lock_q && (acc_w >= lock_lv_w);
  assign restart_w = run_w && lock_q && (acc_w < rel_lv_w);
  assign hold_w    = lock_q || lock_go_w;
  assign int_clr_w = !run_w || half_chg_w || restart_w;

  pid_timebase #(.LINES_PER_SAMPLE(LINES_PER_SAMPLE)) tb_i (
    .clk(clk), .rst_n(rst_n), .clr(!run_w), .ref_tick(ref_tick),
    .ref_x4(ref_x4), .samp_tick(samp_w)
  );

  pid_window #(.HALF_BASE(HALF_BASE)) win_i (
    .clk(clk), .rst_n(rst_n), .clr(!run_w), .restart(restart_w),
    .hold(hold_w), .samp_tick(samp_w), .per_sel(per_sel),
    .sel_stereo(sel_w), .half_chg(half_chg_w)
  );

  pid_integrator #(.AW(AW)) int_i (
    .clk(clk), .rst_n(rst_n), .clr(int_clr_w), .samp_tick(samp_w),
    .det(det_raw), .limit(half_w), .acc(acc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (!run_w) begin
      lock_q <= 1'b0;
    end else if (lock_go_w) begin
      lock_q <= 1'b1;
      mode_q <= sel_w;
    end else if (restart_w) begin
      lock_q <= 1'b0;
    end
  end

  always_comb begin
    if (!search_en)            status_w = ST_MONO;
    else if (per_sel == 2'b11) status_w = ST_INHIB;
    else if (lock_q)           status_w = mode_q ? ST_STEREO : ST_DUAL;
    else                       status_w = ST_MONO;
  end

  assign id_status   = status_w;
  assign filt_stereo = sel_w;
  assign locked      = lock_q;

  // R7: while locked the filter stays on the confirmed mode
  p_sel_matches_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (sel_w == mode_q));

  // R1: disabled search leaves no lock and the dual filter selected
  p_mono_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> (!lock_q && !sel_w));

  // R5: a new lock needs the integrator at or above the lock level
  p_lock_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(acc_w) >= $past(lock_lv_w)));

endmodule

// File: tb/pilot_id_seq_tb_top.sv
module pilot_id_seq_tb_top;
  localparam int LPS = 2;
  localparam int HB  = 8;
  localparam int S   = 4 * LPS;   // clocks per sample (ref tick every 4 clocks at x1)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       ref_x4 = 1'b0;
  logic [1:0] per_sel = 2'b00;
  logic       search_en = 1'b0;
  logic       det_raw = 1'b0;
  logic       filt_stereo;
  logic [1:0] id_status;
  logic       locked;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pilot_id_seq #(.LINES_PER_SAMPLE(LPS), .HALF_BASE(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_x4(ref_x4),
    .per_sel(per_sel), .search_en(search_en), .det_raw(det_raw),
    .filt_stereo(filt_stereo), .id_status(id_status), .locked(locked)
  );

  // reference tick: every 4 clocks at line rate, every clock at 4x
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      ref_tick = ref_x4 ? 1'b1 : (div == 0);
      div = (div + 1) % 4;
    end
  end

  function automatic int half_of(int p);
    return HB * (1 << p);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    check((act >= exp - S) && (act <= exp + S), req, act, exp);
  endtask

  // wait until the chosen output (0 filt_stereo, 1 locked) equals v
  task automatic wait_out(input int which, input logic v, input int maxc, output int t);
    t = 0;
    while (t < maxc) begin
      @(negedge clk);
      t++;
      if ((which == 0 ? filt_stereo : locked) == v) return;
    end
    t = -1;
  endtask

  task automatic restart_cfg(input int p, input logic x4);
    search_en = 1'b0;
    det_raw   = 1'b0;
    repeat (6) @(negedge clk);
    per_sel = 2'(p);
    ref_x4  = x4;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int t;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(id_status == 2'b00 && !filt_stereo && !locked, "R1 reset", int'(id_status), 0);

    // R1: mono hold ignores detect
    det_raw = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (id_status != 2'b00 || filt_stereo || locked) seen = 1;
      end
      check(!seen, "R1 mono hold with detect", int'(seen), 0);
    end

    // R2/R3: half length for every period code and reference rate
    for (int p = 0; p < 3; p++) begin
      for (int x = 0; x < 2; x++) begin
        restart_cfg(p, x[0]);
        h = half_of(p);
        search_en = 1'b1;
        wait_out(0, 1'b1, 4 * h * S, t);
        near($sformatf("R2 R3 first half p=%0d x4=%0d", p, x), t, h * S);
        wait_out(0, 1'b0, 4 * h * S, t);
        near($sformatf("R3 second half p=%0d x4=%0d", p, x), t, h * S);
        check(id_status == 2'b00, "R3 mono while searching", int'(id_status), 0);
      end
    end

    // R5/R7: dual lock, quarter period latency, frozen select
    for (int p = 0; p < 3; p++) begin
      restart_cfg(p, 1'b0);
      h = half_of(p);
      det_raw = 1'b1;
      search_en = 1'b1;
      wait_out(1, 1'b1, 4 * h * S, t);
      near($sformatf("R5 dual lock time p=%0d", p), t, (h / 2) * S);
      check(id_status == 2'b10, "R7 dual status", int'(id_status), 2);
      begin
        bit moved = 0;
        for (int i = 0; i < 3 * h * S; i++) begin
          @(negedge clk);
          if (filt_stereo || !locked) moved = 1;
        end
        check(!moved, "R7 dual select frozen", int'(moved), 0);
      end
      // R4/R8: saturated at H, release after H - H/4 + 1 samples
      det_raw = 1'b0;
      wait_out(1, 1'b0, 4 * h * S, t);
      near($sformatf("R4 R8 release time p=%0d", p), t, (h - h / 4 + 1) * S);
      check(id_status == 2'b00 && !filt_stereo, "R8 back to mono dual", int'(id_status), 0);
      wait_out(0, 1'b1, 4 * h * S, t);
      near("R8 full dual half after release", t, h * S);
    end

    // R7: stereo lock
    restart_cfg(1, 1'b1);
    h = half_of(1);
    search_en = 1'b1;
    wait_out(0, 1'b1, 4 * h * S, t);
    det_raw = 1'b1;
    wait_out(1, 1'b1, 4 * h * S, t);
    near("R5 stereo lock time", t, (h / 2) * S);
    check(id_status == 2'b01, "R7 stereo status", int'(id_status), 1);
    repeat (3 * h * S) @(negedge clk);
    check(filt_stereo && locked, "R7 stereo select frozen", int'(filt_stereo), 1);
    det_raw = 1'b0;
    wait_out(1, 1'b0, 4 * h * S, t);
    check(!filt_stereo && id_status == 2'b00, "R8 stereo release to dual", int'(filt_stereo), 0);

    // R4: integrator cleared at half change
    restart_cfg(2, 1'b0);
    h = half_of(2);
    search_en = 1'b1;
    repeat ((h - 6) * S) @(negedge clk);
    det_raw = 1'b1;
    wait_out(0, 1'b1, 4 * h * S, t);
    check(!locked, "R4 no lock from partial dual half", int'(locked), 0);
    wait_out(1, 1'b1, 4 * h * S, t);
    near("R4 lock counted from half start", t, (h / 2) * S);

    // R6: sparse detect hits
    restart_cfg(0, 1'b0);
    h = half_of(0);
    search_en = 1'b1;
    begin
      bit any = 0;
      for (int k = 0; k < 16; k++) begin
        det_raw = 1'b1;
        for (int i = 0; i < S; i++) begin @(negedge clk); if (locked) any = 1; end
        det_raw = 1'b0;
        for (int i = 0; i < 3 * S; i++) begin @(negedge clk); if (locked) any = 1; end
      end
      check(!any, "R6 sparse hits rejected", int'(any), 0);
    end

    // R9: reserved period code
    restart_cfg(3, 1'b0);
    search_en = 1'b1;
    det_raw = 1'b1;
    repeat (200) @(negedge clk);
    check(id_status == 2'b11, "R9 inhibited status", int'(id_status), 3);
    check(!filt_stereo && !locked, "R9 search stopped", int'(locked), 0);

    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule